// File: doc/BRIEF.md
# Serial Link Handshake Controller

This block is the device end of a byte-wide serial link to a host. Three active-low handshake lines pace the link: the host drives transfer-in-progress and acknowledge, and the device drives request. A direction input tells the block which way the shift register is moving.

While the host holds transfer-in-progress low, the block works in one of two ways. In host-to-device mode, each change of the line pair stores the shift-register byte into a packet buffer. In device-to-host mode, each change hands the next queued reply byte to the shift register. When the host lets transfer-in-progress go, the block reports the captured packet and its length.

Between transfers the request line tells the host that reply bytes are waiting. In a separate sync mode the request line follows the acknowledge line. Every step arms a timer, and a shift-register interrupt pulse is raised only when that timer runs out. The block also pulses an output to block autopolling when a host packet starts, and another to unblock it when the last reply byte has left.

Top module: `shk_link_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, hs_req_n is 1, and sr_irq, pkt_done, poll_block and poll_unblock are 0. Reset also clears all counts and lengths, and the stored previous line sample is set to both lines high.
- R2: Host-to-device capture. With hs_tip_n low and dir_to_dev high, any clock where the pair {hs_tip_n, hs_ack_n} differs from the previous clock's sample stores sr_in at the next buffer index. The stored bytes can be read back through pkt_rd_addr and pkt_rd_data.
- R3: poll_block pulses for one cycle after the first byte of a packet is stored, and at no other time.
- R4: Once OUT_DEPTH bytes are held, further changes store nothing and schedule no interrupt. The packet is then reported with length OUT_DEPTH.
- R5: Device-to-host delivery. With hs_tip_n low and dir_to_dev low, a pair change while unread reply bytes remain loads the next reply byte onto sr_out. When no bytes remain, sr_out is unchanged.
- R6: Delivering the last reply byte drives hs_req_n to 1 and pulses poll_unblock for one cycle.
- R7: Each scheduled step produces one single-cycle sr_irq pulse exactly DELAY_CYC cycles later. DELAY_CYC is CLK_HZ × DELAY_NS / 10^9. Scheduling again while the timer is pending restarts the count.
- R8: Sync mode. With hs_tip_n high on this clock and the previous clock, a change of hs_ack_n makes hs_req_n equal to the new hs_ack_n level and schedules an interrupt.
- R9: The clock after hs_tip_n rises, the block schedules an interrupt and clears the capture count. If the count was nonzero, pkt_done pulses for one cycle and pkt_len shows the count.
- R10: With hs_tip_n high and no acknowledge change, hs_req_n is driven to 0 whenever unread reply bytes are queued.
- R11: A pulse on rpl_load sets the reply length to rpl_len, resets the read index to zero and schedules an interrupt. In the same cycle it overrides a delivery step, so no byte is delivered in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_tip_n | input | 1 | Transfer in progress from host, active low |
| hs_ack_n | input | 1 | Acknowledge from host, active low |
| hs_req_n | output | 1 | Request to host, active low: reply data waiting |
| dir_to_dev | input | 1 | 1 = host-to-device shift direction |
| sr_in | input | 8 | Shift-register byte written by host |
| sr_out | output | 8 | Reply byte presented to host |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |
| pkt_done | output | 1 | One-cycle pulse: host packet complete |
| pkt_len | output | CW | Length of the last completed packet |
| pkt_rd_addr | input | OAW | Read address into the capture buffer |
| pkt_rd_data | output | 8 | Captured byte at pkt_rd_addr |
| rpl_wr_en | input | 1 | Write a reply buffer byte |
| rpl_wr_addr | input | RAW | Reply buffer write address |
| rpl_wr_data | input | 8 | Reply buffer write data |
| rpl_load | input | 1 | Commit a reply packet of length rpl_len |
| rpl_len | input | RLW | Reply packet length, clipped to RPL_DEPTH |
| poll_block | output | 1 | Pulse: host packet started, stop autopolling |
| poll_unblock | output | 1 | Pulse: reply drained, resume autopolling |

## Verification
The critical coincidence is a reply packet commit landing on the same clock as a handshake step. One case is the host releasing transfer-in-progress. The other is an acknowledge change during a device-to-host read. Both the step and the commit schedule the interrupt, and the commit must win over the read index.

Directed sequences drive rpl_load on the exact clock of a release, and random stimulus scatters commits across delivery bursts. A cycle-accurate reference model in the bench then judges both outcomes. It checks that pkt_done and pkt_len report the old packet while the new reply length takes effect. It also checks that only one interrupt pulse follows, and that no byte moves in the overridden cycle.

// File: rtl/shk_pkg.sv
`timescale 1ns/1ps
package shk_pkg;

    typedef enum logic [2:0] {
        STEP_NONE,
        STEP_CAPTURE,
        STEP_DELIVER,
        STEP_SYNC,
        STEP_RELEASE,
        STEP_IDLE
    } step_t;

    typedef struct packed {
        logic tip_n;
        logic ack_n;
    } hs_pair_t;

    localparam hs_pair_t PAIR_INACTIVE = '{tip_n: 1'b1, ack_n: 1'b1};

    function automatic int unsigned delay_cycles(longint unsigned hz,
                                                 longint unsigned ns);
        longint unsigned c;
        c = (hz * ns) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/shk_delay_timer.sv
`timescale 1ns/1ps
module shk_delay_timer #(
    parameter int unsigned DELAY_CYC = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic sched,
    output logic irq
);
    localparam int TW = $clog2(DELAY_CYC + 1);
    localparam logic [TW-1:0] LOAD = TW'(DELAY_CYC);

    logic [TW-1:0] cnt;
    logic          pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= pend && (cnt == TW'(1));
            if (sched) begin
                cnt  <= LOAD;
                pend <= 1'b1;
            end else if (pend) begin
                cnt  <= cnt - TW'(1);
                pend <= (cnt != TW'(1));
            end
        end
    end

    // R7: a pulse only ever follows a pending count
    a_r7_fire_after_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(pend));
    // R7: a schedule always leaves the timer pending
    a_r7_sched_arms: assert property (@(posedge clk) disable iff (rst)
        sched |=> pend);
endmodule

// File: rtl/shk_capture_buf.sv
`timescale 1ns/1ps
module shk_capture_buf #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       store,
    input  logic [7:0]                 data,
    input  logic                       clear,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [7:0]                 rd_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (store && !full) begin
            count <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (store && !full) mem[count[AW-1:0]] <= data;
    end

    // R4: count never passes the buffer depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R4: a store into a full buffer leaves the count alone
    a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !clear) |=> full);
endmodule

// File: rtl/shk_reply_buf.sv
`timescale 1ns/1ps
module shk_reply_buf #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       load,
    input  logic [$clog2(DEPTH+1)-1:0] load_len,
    input  logic                       advance,
    output logic [7:0]                 cur_byte,
    output logic                       has_more,
    output logic                       is_last
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] idx;
    logic [LW-1:0] len;
    logic [LW-1:0] len_clip;
    logic [LW:0]   idx_next;

    assign len_clip = (load_len > LW'(DEPTH)) ? LW'(DEPTH) : load_len;
    assign has_more = (idx < len);
    assign idx_next = {1'b0, idx} + (LW+1)'(1);
    assign is_last  = has_more && (idx_next >= {1'b0, len});
    assign cur_byte = mem[idx[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            len <= '0;
        end else if (load) begin
            idx <= '0;
            len <= len_clip;
        end else if (advance && has_more) begin
            idx <= idx + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // R5: read index stays within the committed length
    a_r5_index_bound: assert property (@(posedge clk) disable iff (rst)
        idx <= len);
    // R11: a commit restarts reading at the first byte
    a_r11_load_restart: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx == '0));
endmodule

// File: rtl/shk_link_ctrl.sv
`timescale 1ns/1ps
module shk_link_ctrl
    import shk_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 200_000_000,
    parameter longint unsigned DELAY_NS  = 20_000,
    parameter int              OUT_DEPTH = 16,
    parameter int              RPL_DEPTH = 16,
    localparam int CW  = $clog2(OUT_DEPTH + 1),
    localparam int OAW = $clog2(OUT_DEPTH),
    localparam int RLW = $clog2(RPL_DEPTH + 1),
    localparam int RAW = $clog2(RPL_DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hs_tip_n,
    input  logic           hs_ack_n,
    output logic           hs_req_n,
    input  logic           dir_to_dev,
    input  logic [7:0]     sr_in,
    output logic [7:0]     sr_out,
    output logic           sr_irq,
    output logic           pkt_done,
    output logic [CW-1:0]  pkt_len,
    input  logic [OAW-1:0] pkt_rd_addr,
    output logic [7:0]     pkt_rd_data,
    input  logic           rpl_wr_en,
    input  logic [RAW-1:0] rpl_wr_addr,
    input  logic [7:0]     rpl_wr_data,
    input  logic           rpl_load,
    input  logic [RLW-1:0] rpl_len,
    output logic           poll_block,
    output logic           poll_unblock
);
    localparam int unsigned DELAY_CYC = delay_cycles(CLK_HZ, DELAY_NS);

    hs_pair_t      prev;
    hs_pair_t      now_pair;
    step_t         step;
    logic          changed;
    logic          do_cap;
    logic          do_del;
    logic          sched;
    logic [CW-1:0] cap_count;
    logic          cap_full;
    logic [7:0]    rpl_byte;
    logic          rpl_more;
    logic          rpl_last;

    assign now_pair = '{tip_n: hs_tip_n, ack_n: hs_ack_n};
    assign changed  = (now_pair != prev);

    always_comb begin
        step = STEP_NONE;
        if (!hs_tip_n) begin
            if (changed) step = dir_to_dev ? STEP_CAPTURE : STEP_DELIVER;
        end else if (prev.tip_n && (hs_ack_n != prev.ack_n)) begin
            step = STEP_SYNC;
        end else if (!prev.tip_n) begin
            step = STEP_RELEASE;
        end else begin
            step = STEP_IDLE;
        end
    end

    assign do_cap = (step == STEP_CAPTURE) && !cap_full;
    assign do_del = (step == STEP_DELIVER) && rpl_more && !rpl_load;
    assign sched  = do_cap || do_del || (step == STEP_SYNC) ||
                    (step == STEP_RELEASE) || rpl_load;

    shk_capture_buf #(.DEPTH(OUT_DEPTH)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .store   (do_cap),
        .data    (sr_in),
        .clear   (step == STEP_RELEASE),
        .count   (cap_count),
        .full    (cap_full),
        .rd_addr (pkt_rd_addr),
        .rd_data (pkt_rd_data)
    );

    shk_reply_buf #(.DEPTH(RPL_DEPTH)) u_rpl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rpl_wr_en),
        .wr_addr  (rpl_wr_addr),
        .wr_data  (rpl_wr_data),
        .load     (rpl_load),
        .load_len (rpl_len),
        .advance  (do_del),
        .cur_byte (rpl_byte),
        .has_more (rpl_more),
        .is_last  (rpl_last)
    );

    shk_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .sched (sched),
        .irq   (sr_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev         <= PAIR_INACTIVE;
            hs_req_n     <= 1'b1;
            sr_out       <= '0;
            pkt_done     <= 1'b0;
            pkt_len      <= '0;
            poll_block   <= 1'b0;
            poll_unblock <= 1'b0;
        end else begin
            prev         <= now_pair;
            pkt_done     <= 1'b0;
            poll_block   <= do_cap && (cap_count == '0);
            poll_unblock <= do_del && rpl_last;
            if (do_del) sr_out <= rpl_byte;
            if (step == STEP_RELEASE && cap_count != '0) begin
                pkt_done <= 1'b1;
                pkt_len  <= cap_count;
            end
            if (do_del && rpl_last) begin
                hs_req_n <= 1'b1;
            end else if (step == STEP_SYNC) begin
                hs_req_n <= hs_ack_n;
            end else if ((step == STEP_RELEASE || step == STEP_IDLE) && rpl_more) begin
                hs_req_n <= 1'b0;
            end
        end
    end

    // R3: block pulse coincides with the first stored byte
    a_r3_block_first: assert property (@(posedge clk) disable iff (rst)
        poll_block |-> (cap_count == CW'(1)));
    // R6: unblock pulse leaves request inactive
    a_r6_unblock_req: assert property (@(posedge clk) disable iff (rst)
        poll_unblock |-> hs_req_n);
    // R9: a reported packet is never empty
    a_r9_done_len: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_len != '0));
    // R9: capture count is empty after a release
    a_r9_release_clears: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_RELEASE) |=> (cap_count == '0));
    // R8: sync step copies the acknowledge level
    a_r8_sync_follow: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_SYNC) |=> (hs_req_n == $past(hs_ack_n)));
endmodule

// File: tb/shk_link_ctrl_test.sv
`timescale 1ns/1ps
module shk_link_ctrl_test;
    localparam int OD = 16;
    localparam int RD = 16;
    localparam int D  = 20; // 200 MHz * 100 ns

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tip = 1'b1, ack = 1'b1, dir = 1'b0;
    logic [7:0] sr_in = '0;
    logic [7:0] sr_out, pkt_rd_data;
    logic req_n, irq, done, blk, unblk;
    logic [4:0] pkt_len;
    logic [3:0] rd_addr = '0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic load = 1'b0;
    logic [4:0] len = '0;

    int checks = 0, errors = 0;
    int blk_cnt = 0, unblk_cnt = 0, irq_cnt = 0;
    int seen_len = 0;

    always #2.5 clk = ~clk;

    shk_link_ctrl #(.CLK_HZ(200_000_000), .DELAY_NS(100),
                    .OUT_DEPTH(OD), .RPL_DEPTH(RD)) uut (
        .clk(clk), .rst(rst), .hs_tip_n(tip), .hs_ack_n(ack), .hs_req_n(req_n),
        .dir_to_dev(dir), .sr_in(sr_in), .sr_out(sr_out), .sr_irq(irq),
        .pkt_done(done), .pkt_len(pkt_len), .pkt_rd_addr(rd_addr),
        .pkt_rd_data(pkt_rd_data), .rpl_wr_en(wr_en), .rpl_wr_addr(wr_addr),
        .rpl_wr_data(wr_data), .rpl_load(load), .rpl_len(len),
        .poll_block(blk), .poll_unblock(unblk)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state, updated from the requirements
    logic m_ptip, m_pack, m_req, m_irq, m_done, m_blk, m_unblk, m_pend;
    logic [7:0] m_sr;
    logic [7:0] m_obuf [OD];
    logic       m_wr [OD];
    logic [7:0] m_rbuf [RD];
    int m_ocnt, m_rlen, m_ridx, m_plen, m_cnt;

    always @(posedge clk) begin
        logic chg, sched, fire;
        if (rst) begin
            m_ptip = 1; m_pack = 1; m_req = 1; m_irq = 0; m_done = 0;
            m_blk = 0; m_unblk = 0; m_pend = 0; m_sr = 0;
            m_ocnt = 0; m_rlen = 0; m_ridx = 0; m_plen = 0; m_cnt = 0;
            for (int i = 0; i < OD; i++) m_wr[i] = 0;
        end else begin
            m_blk = 0; m_unblk = 0; m_done = 0; sched = 0;
            fire = m_pend && (m_cnt == 1);
            chg = (tip != m_ptip) || (ack != m_pack);
            if (!tip) begin
                if (dir) begin
                    if (chg && m_ocnt < OD) begin
                        if (m_ocnt == 0) m_blk = 1;
                        m_obuf[m_ocnt] = sr_in; m_wr[m_ocnt] = 1;
                        m_ocnt++; sched = 1;
                    end
                end else if (chg && !load && m_ridx < m_rlen) begin
                    m_sr = m_rbuf[m_ridx]; m_ridx++;
                    if (m_ridx >= m_rlen) begin m_req = 1; m_unblk = 1; end
                    sched = 1;
                end
            end else if (m_ptip && ack != m_pack) begin
                m_req = ack; sched = 1;
            end else begin
                if (!m_ptip) begin
                    if (m_ocnt > 0) begin m_done = 1; m_plen = m_ocnt; end
                    m_ocnt = 0; sched = 1;
                end
                if (m_ridx < m_rlen) m_req = 0;
            end
            if (load) begin m_ridx = 0; m_rlen = (int'(len) > RD) ? RD : int'(len); sched = 1; end
            if (wr_en) m_rbuf[wr_addr] = wr_data;
            m_irq = fire;
            if (sched) begin m_cnt = D; m_pend = 1; end
            else if (m_pend) begin
                if (m_cnt == 1) m_pend = 0;
                m_cnt--;
            end
            m_ptip = tip; m_pack = ack;
        end
    end

    // per-cycle comparison and pulse monitors, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(req_n == m_req, "R10 req_n", int'(req_n), int'(m_req));
            check(irq == m_irq, "R7 sr_irq", int'(irq), int'(m_irq));
            check(done == m_done, "R9 pkt_done", int'(done), int'(m_done));
            check(blk == m_blk, "R3 poll_block", int'(blk), int'(m_blk));
            check(unblk == m_unblk, "R6 poll_unblock", int'(unblk), int'(m_unblk));
            check(sr_out == m_sr, "R5 sr_out", int'(sr_out), int'(m_sr));
            check(int'(pkt_len) == m_plen, "R9 pkt_len", int'(pkt_len), m_plen);
            if (m_wr[rd_addr])
                check(pkt_rd_data == m_obuf[rd_addr], "R2 pkt_rd_data",
                      int'(pkt_rd_data), int'(m_obuf[rd_addr]));
            if (blk) blk_cnt++;
            if (unblk) unblk_cnt++;
            if (irq) irq_cnt++;
            if (done) seen_len = int'(pkt_len);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic toggle_ack(input logic [7:0] b);
        sr_in = b; ack = ~ack; cyc(1);
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b0, i0;
        void'($urandom(32'h5EED_1234));
        cyc(3);
        // R1: reset state
        check(req_n == 1'b1, "R1 req_n in reset", int'(req_n), 1);
        check(irq == 1'b0 && done == 1'b0, "R1 irq/done in reset", int'(irq | done), 0);
        rst = 1'b0; cyc(1);
        check(req_n == 1'b1 && blk == 1'b0, "R1 after reset", int'(req_n), 1);

        // R2/R3: capture three bytes, then release
        dir = 1; b0 = blk_cnt;
        sr_in = 8'hA5; tip = 0; cyc(1);
        toggle_ack(8'h3C); toggle_ack(8'h7E);
        tip = 1; ack = 1; cyc(4);
        check(seen_len == 3, "R9 packet length", seen_len, 3);
        rd_addr = 0; cyc(1);
        check(pkt_rd_data == 8'hA5, "R2 first byte", int'(pkt_rd_data), 'hA5);
        rd_addr = 2; cyc(1);
        check(pkt_rd_data == 8'h7E, "R2 third byte", int'(pkt_rd_data), 'h7E);
        check(blk_cnt - b0 == 1, "R3 one block pulse", blk_cnt - b0, 1);
        cyc(30);

        // R11/R10: commit a three-byte reply
        for (int k = 0; k < 3; k++) begin
            wr_en = 1; wr_addr = 4'(k); wr_data = 8'(8'h10 + k); cyc(1);
        end
        wr_en = 0; i0 = irq_cnt;
        load = 1; len = 3; cyc(1); load = 0; cyc(3);
        check(req_n == 1'b0, "R10 req asserted with data", int'(req_n), 0);
        cyc(D + 2);
        check(irq_cnt - i0 == 1, "R11 load interrupt", irq_cnt - i0, 1);

        // R5/R6: deliver them
        dir = 0; b0 = unblk_cnt;
        tip = 0; cyc(1);
        toggle_ack(0); toggle_ack(0); cyc(2);
        check(sr_out == 8'h12, "R5 last byte", int'(sr_out), 'h12);
        check(req_n == 1'b1, "R6 req released", int'(req_n), 1);
        check(unblk_cnt - b0 == 1, "R6 unblock pulse", unblk_cnt - b0, 1);
        toggle_ack(0); cyc(2);
        check(sr_out == 8'h12, "R5 no byte past end", int'(sr_out), 'h12);
        tip = 1; ack = 1; cyc(30);

        // R4: overfill the capture buffer
        dir = 1; sr_in = 8'h00; tip = 0; cyc(1);
        for (int k = 1; k < OD + 3; k++) toggle_ack(8'(k));
        tip = 1; ack = 1; cyc(4);
        check(seen_len == OD, "R4 full length", seen_len, OD);
        rd_addr = 4'(OD - 1); cyc(1);
        check(pkt_rd_data == 8'(OD - 1), "R4 last stored byte", int'(pkt_rd_data), OD - 1);
        cyc(30);

        // R8: sync mode mirrors acknowledge
        ack = 0; cyc(2);
        check(req_n == 1'b0, "R8 req follows ack low", int'(req_n), 0);
        ack = 1; cyc(2);
        check(req_n == 1'b1, "R8 req follows ack high", int'(req_n), 1);
        cyc(30);

        // R7: restart while pending gives one pulse
        i0 = irq_cnt;
        ack = 0; cyc(5); ack = 1; cyc(D - 2);
        check(irq_cnt - i0 == 0, "R7 restarted count", irq_cnt - i0, 0);
        cyc(6);
        check(irq_cnt - i0 == 1, "R7 single pulse", irq_cnt - i0, 1);
        cyc(30);

        // R9 + R11 in one cycle: release coincides with a reply commit
        dir = 1; sr_in = 8'h99; tip = 0; cyc(1);
        wr_en = 1; wr_addr = 0; wr_data = 8'h55; cyc(1); wr_en = 0;
        i0 = irq_cnt;
        tip = 1; load = 1; len = 1; cyc(1); load = 0; cyc(3);
        check(seen_len == 1, "R9 release with commit", seen_len, 1);
        check(req_n == 1'b0, "R11 reply pending", int'(req_n), 0);
        cyc(D + 2);
        check(irq_cnt - i0 == 1, "R11 merged interrupt", irq_cnt - i0, 1);
        dir = 0; tip = 0; load = 1; len = 1; cyc(1); load = 0; cyc(2);
        check(sr_out == 8'h12, "R11 commit overrides delivery", int'(sr_out), 'h12);
        tip = 1; cyc(30);

        // random mix, judged by the reference model
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 39) == 0) tip = ~tip;
            if ($urandom_range(0, 2) == 0) ack = ~ack;
            if (tip && $urandom_range(0, 9) == 0) dir = ~dir;
            sr_in = 8'($urandom);
            rd_addr = 4'($urandom);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_addr = 4'($urandom); wr_data = 8'($urandom);
            load = ($urandom_range(0, 59) == 0);
            len = 5'($urandom_range(0, RD));
            cyc(1);
        end
        load = 0; wr_en = 0; tip = 1; cyc(D + 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule